// File: doc/BRIEF.md
# Host-Slave Dual Mailbox Bus Port

This block sits between an asynchronous host processor bus and a small embedded controller core. It gives the two sides a pair of one-byte mailboxes. The inbound mailbox is filled by the host and drained by the core. The outbound mailbox is filled by the core and drained by the host. An eight-bit status byte carries the handshake flags, a host-written command/data marker, a core-owned flag, and four bits that the core loads from its accumulator. The host can read the status byte at any time.

The host strobes (chip select, address bit, read, write and data) pass through a two-flop synchronizer into the core clock. A four-state machine then follows each host cycle. The states are HS_IDLE, HS_WRITE, HS_RD_DATA and HS_RD_STAT. The transitions are:

- HS_IDLE to HS_WRITE when a selected write strobe is seen low.
- HS_IDLE to HS_RD_STAT when a selected read strobe is seen low with the address bit at 1.
- HS_IDLE to HS_RD_DATA when a selected read strobe is seen low with the address bit at 0.
- From HS_WRITE, HS_RD_DATA or HS_RD_STAT back to HS_IDLE when the synchronized strobe returns high.

That last transition is the trailing edge. It is the only point at which host-caused flag changes take effect.

The core drives its side with decoded single-cycle strobes and an opcode byte. Two opcodes matter here: one uploads the user status nibble, the other permanently switches two port pins into host-interrupt mode.

Top module: `hsb_mailbox`

## Requirements
- R1: After reset, the status byte reads 0x00, the inbound mailbox holds 0x00, both port latches hold 1, both pins drive 1, flag mode is off, and `h_dout_en` is 0 while no selected read is active.
- R2: A selected host write loads `h_din` into the inbound mailbox, sets the inbound-full flag (status bit 1) and copies `h_a0` into the command flag (status bit 3). None of these changes appear while the write strobe is still low; they appear only after it returns high.
- R3: A selected host read with `h_a0`=0 drives the outbound mailbox on `h_dout` with `h_dout_en`=1. The outbound-full flag (status bit 0) clears only after the read strobe returns high.
- R4: A selected host read with `h_a0`=1 returns the status byte in this layout, bit 7 to bit 0: user bits 3..0, command flag, core flag, inbound-full, outbound-full. A status read changes no flag.
- R5: `c_obuf_wr` loads `c_acc` into the outbound mailbox and sets outbound-full. `c_ibuf_rd` clears inbound-full, and `c_ibuf_q` always shows the inbound mailbox.
- R6: When `c_op_vld` is high with `c_op`=0x90, status bits 7..4 take `c_acc[7:4]` and status bits 3..0 stay unchanged. Any other opcode leaves bits 7..4 unchanged.
- R7: The core flag (status bit 2) changes only through `c_f0_wr`, which writes `c_f0_val`. Host reads and writes leave it alone.
- R8: While a host status read is in progress, the status byte seen by the host and by the pins stays frozen. Core updates made during the read still reach `c_sts` at once and become visible to the host after the read ends.
- R9: In port mode, `pin_obf` follows port latch bit 0 and `pin_ibf_n` follows port latch bit 1 (both loaded by `c_plat_we`). Opcode 0xF5 enters flag mode, and flag mode lasts until reset; no other opcode enters it or leaves it.
- R10: In flag mode, `pin_obf` equals outbound-full when latch bit 0 is 1 and is 0 otherwise. `pin_ibf_n` equals the inverse of inbound-full when latch bit 1 is 1 and is 0 otherwise.
- R11: If a host write ends in the same cycle as `c_ibuf_rd`, inbound-full stays set. If a host data read ends in the same cycle as `c_obuf_wr`, outbound-full stays set and the mailbox holds the new byte.
- R12: Read and write strobes given while `h_cs_n` is 1 have no effect on the mailboxes or flags, and they leave `h_dout_en` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_a0 | input | 1 | Host address bit: 1 selects status/command, 0 selects data |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_din | input | 8 | Host write data |
| h_dout | output | 8 | Host read data, 0 when not driving |
| h_dout_en | output | 1 | High while a selected host read is active |
| c_op_vld | input | 1 | Core opcode strobe |
| c_op | input | 8 | Core opcode byte |
| c_acc | input | 8 | Core accumulator value |
| c_obuf_wr | input | 1 | Core write of outbound mailbox |
| c_ibuf_rd | input | 1 | Core read of inbound mailbox |
| c_ibuf_q | output | 8 | Inbound mailbox contents |
| c_f0_wr | input | 1 | Core write of core flag |
| c_f0_val | input | 1 | Value for core flag |
| c_plat_we | input | 1 | Port latch write strobe |
| c_plat_d | input | 2 | Port latch data; bit 0 for `pin_obf`, bit 1 for `pin_ibf_n` |
| c_sts | output | 8 | Live status byte for the core |
| pin_obf | output | 1 | Port pin / outbound-full interrupt |
| pin_ibf_n | output | 1 | Port pin / inbound-empty interrupt |

## Verification
The assertions assume two things about the host. First, it holds chip select, the address bit and write data steady for the whole time a strobe is low, and for at least three core clocks after the strobe rises. Second, it never lowers read and write together. The stimulus keeps to both: it sets up select and address one cycle before each strobe, holds every strobe for six cycles, keeps select for five cycles after release, and drives only one strobe at a time. Core strobes are one-cycle pulses launched on the falling clock edge. The two same-cycle collisions are placed by counting exactly three rising edges after the host strobe is released.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    localparam int DW      = 8;
    localparam int B_OBF   = 0;
    localparam int B_IBF   = 1;
    localparam int B_F0    = 2;
    localparam int B_F1    = 3;
    localparam int B_USR   = 4;
    localparam int USR_W   = DW - B_USR;
    localparam int NPIN    = 2;

    localparam logic [DW-1:0] OP_STS_LOAD = 8'h90;
    localparam logic [DW-1:0] OP_FLAG_ON  = 8'hF5;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_WRITE,
        HS_RD_DATA,
        HS_RD_STAT
    } hs_state_t;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
    parameter int              WIDTH   = 12,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hsb_host_fsm.sv
module hsb_host_fsm
    import hsb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          a0_s,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    input  logic [DW-1:0] din_s,
    output logic          wr_done,
    output logic          rdd_done,
    output logic          sts_lock,
    output logic [DW-1:0] cap_din,
    output logic          cap_a0
);
    hs_state_t state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            HS_IDLE: begin
                if (!cs_n_s && !wr_n_s)      state_n = HS_WRITE;
                else if (!cs_n_s && !rd_n_s) state_n = a0_s ? HS_RD_STAT : HS_RD_DATA;
            end
            HS_WRITE:   if (wr_n_s) state_n = HS_IDLE;
            HS_RD_DATA: if (rd_n_s) state_n = HS_IDLE;
            HS_RD_STAT: if (rd_n_s) state_n = HS_IDLE;
            default:    state_n = HS_IDLE;
        endcase
    end

    always_comb begin
        wr_done  = (state_q == HS_WRITE)   && wr_n_s;
        rdd_done = (state_q == HS_RD_DATA) && rd_n_s;
        sts_lock = (state_q == HS_RD_STAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_din <= '0;
            cap_a0  <= 1'b0;
        end else if (state_n == HS_WRITE && !wr_n_s) begin
            cap_din <= din_s;
            cap_a0  <= a0_s;
        end
    end
endmodule

// File: rtl/hsb_flag_regs.sv
module hsb_flag_regs
    import hsb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_done,
    input  logic          rdd_done,
    input  logic          sts_lock,
    input  logic [DW-1:0] cap_din,
    input  logic          cap_a0,
    input  logic          c_op_vld,
    input  logic [DW-1:0] c_op,
    input  logic [DW-1:0] c_acc,
    input  logic          c_obuf_wr,
    input  logic          c_ibuf_rd,
    input  logic          c_f0_wr,
    input  logic          c_f0_val,
    output logic [DW-1:0] ibuf_q,
    output logic [DW-1:0] obuf_q,
    output logic [DW-1:0] sts_live,
    output logic [DW-1:0] sts_vis,
    output logic          flag_mode
);
    logic             ibf_q, obf_q, f0_q, f1_q;
    logic [USR_W-1:0] usr_q;
    logic             op_sts, op_flag;

    assign op_sts  = c_op_vld && (c_op == OP_STS_LOAD);
    assign op_flag = c_op_vld && (c_op == OP_FLAG_ON);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibuf_q    <= '0;
            obuf_q    <= '0;
            ibf_q     <= 1'b0;
            obf_q     <= 1'b0;
            f0_q      <= 1'b0;
            f1_q      <= 1'b0;
            usr_q     <= '0;
            flag_mode <= 1'b0;
        end else begin
            if (wr_done) begin
                ibuf_q <= cap_din;
                f1_q   <= cap_a0;
                ibf_q  <= 1'b1;
            end else if (c_ibuf_rd) begin
                ibf_q  <= 1'b0;
            end
            if (c_obuf_wr) begin
                obuf_q <= c_acc;
                obf_q  <= 1'b1;
            end else if (rdd_done) begin
                obf_q  <= 1'b0;
            end
            if (c_f0_wr) f0_q <= c_f0_val;
            if (op_sts)  usr_q <= c_acc[DW-1:B_USR];
            if (op_flag) flag_mode <= 1'b1;
        end
    end

    always_comb begin
        sts_live               = '0;
        sts_live[DW-1:B_USR]   = usr_q;
        sts_live[B_F1]         = f1_q;
        sts_live[B_F0]         = f0_q;
        sts_live[B_IBF]        = ibf_q;
        sts_live[B_OBF]        = obf_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         sts_vis <= '0;
        else if (!sts_lock) sts_vis <= sts_live;
    end
endmodule

// File: rtl/hsb_pin_mux.sv
module hsb_pin_mux
    import hsb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            c_plat_we,
    input  logic [NPIN-1:0] c_plat_d,
    input  logic            flag_mode,
    input  logic [DW-1:0]   sts_vis,
    output logic [NPIN-1:0] plat_q,
    output logic [NPIN-1:0] pins
);
    logic [NPIN-1:0] flag_src;

    always_ff @(posedge clk) begin
        if (!rst_n)         plat_q <= '1;
        else if (c_plat_we) plat_q <= c_plat_d;
    end

    assign flag_src[0] = sts_vis[B_OBF];
    assign flag_src[1] = ~sts_vis[B_IBF];

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign pins[p] = flag_mode ? (plat_q[p] & flag_src[p]) : plat_q[p];
    end
endmodule

// File: rtl/hsb_mailbox.sv
module hsb_mailbox
    import hsb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_cs_n,
    input  logic          h_a0,
    input  logic          h_rd_n,
    input  logic          h_wr_n,
    input  logic [7:0]    h_din,
    output logic [7:0]    h_dout,
    output logic          h_dout_en,
    input  logic          c_op_vld,
    input  logic [7:0]    c_op,
    input  logic [7:0]    c_acc,
    input  logic          c_obuf_wr,
    input  logic          c_ibuf_rd,
    output logic [7:0]    c_ibuf_q,
    input  logic          c_f0_wr,
    input  logic          c_f0_val,
    input  logic          c_plat_we,
    input  logic [1:0]    c_plat_d,
    output logic [7:0]    c_sts,
    output logic          pin_obf,
    output logic          pin_ibf_n
);
    localparam int SW = DW + 4;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

    logic [SW-1:0]   sync_d, sync_q;
    logic            cs_n_s, a0_s, rd_n_s, wr_n_s;
    logic [DW-1:0]   din_s;
    logic            wr_done, rdd_done, sts_lock, cap_a0, flag_mode;
    logic [DW-1:0]   cap_din, ibuf_q, obuf_q, sts_live, sts_vis;
    logic [NPIN-1:0] plat_q, pins;

    assign sync_d = {h_cs_n, h_a0, h_rd_n, h_wr_n, h_din};
    assign {cs_n_s, a0_s, rd_n_s, wr_n_s, din_s} = sync_q;

    hsb_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sync_d), .q(sync_q)
    );

    hsb_host_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_n_s), .a0_s(a0_s), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s), .din_s(din_s),
        .wr_done(wr_done), .rdd_done(rdd_done), .sts_lock(sts_lock),
        .cap_din(cap_din), .cap_a0(cap_a0)
    );

    hsb_flag_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_done(wr_done), .rdd_done(rdd_done), .sts_lock(sts_lock),
        .cap_din(cap_din), .cap_a0(cap_a0),
        .c_op_vld(c_op_vld), .c_op(c_op), .c_acc(c_acc),
        .c_obuf_wr(c_obuf_wr), .c_ibuf_rd(c_ibuf_rd),
        .c_f0_wr(c_f0_wr), .c_f0_val(c_f0_val),
        .ibuf_q(ibuf_q), .obuf_q(obuf_q),
        .sts_live(sts_live), .sts_vis(sts_vis), .flag_mode(flag_mode)
    );

    hsb_pin_mux u_pins (
        .clk(clk), .rst_n(rst_n),
        .c_plat_we(c_plat_we), .c_plat_d(c_plat_d),
        .flag_mode(flag_mode), .sts_vis(sts_vis),
        .plat_q(plat_q), .pins(pins)
    );

    assign h_dout_en = ~h_cs_n & ~h_rd_n;
    assign h_dout    = h_dout_en ? (h_a0 ? sts_vis : obuf_q) : '0;
    assign c_ibuf_q  = ibuf_q;
    assign c_sts     = sts_live;
    assign pin_obf   = pins[0];
    assign pin_ibf_n = pins[1];
endmodule

// File: rtl/hsb_mailbox_chk.sv
module hsb_mailbox_chk
    import hsb_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_done,
    input logic          rdd_done,
    input logic          sts_lock,
    input logic [DW-1:0] sts_live,
    input logic [DW-1:0] sts_vis,
    input logic          flag_mode,
    input logic [1:0]    plat_q,
    input logic          pin_obf,
    input logic          pin_ibf_n,
    input logic          c_obuf_wr,
    input logic          c_f0_wr,
    input logic          c_op_vld,
    input logic [DW-1:0] c_op
);
    // R2
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_live[B_IBF]) |-> $past(wr_done));

    // R3
    obf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_live[B_OBF]) |-> $past(rdd_done));

    // R5
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_live[B_OBF]) |-> $past(c_obuf_wr));

    // R6
    usr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_live[DW-1:B_USR] != $past(sts_live[DW-1:B_USR]))
            |-> $past(c_op_vld && (c_op == OP_STS_LOAD)));

    // R7
    f0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_live[B_F0] != $past(sts_live[B_F0])) |-> $past(c_f0_wr));

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_lock ##1 sts_lock |-> $stable(sts_vis));

    // R9
    mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flag_mode) |-> flag_mode);

    // R10
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_mode && !plat_q[0]) |-> !pin_obf);

    // R10
    pin_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_mode && sts_vis[B_IBF]) |-> !pin_ibf_n);

    // R11
    ibf_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_done) |-> sts_live[B_IBF]);

    // R11
    obf_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(c_obuf_wr) |-> sts_live[B_OBF]);
endmodule

bind hsb_mailbox hsb_mailbox_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_done(wr_done), .rdd_done(rdd_done), .sts_lock(sts_lock),
    .sts_live(sts_live), .sts_vis(sts_vis), .flag_mode(flag_mode),
    .plat_q(plat_q), .pin_obf(pin_obf), .pin_ibf_n(pin_ibf_n),
    .c_obuf_wr(c_obuf_wr), .c_f0_wr(c_f0_wr), .c_op_vld(c_op_vld), .c_op(c_op)
);

// File: tb/hsb_mailbox_tb.sv
`timescale 1ns/1ps
module hsb_mailbox_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_cs_n = 1'b1, h_a0 = 1'b0, h_rd_n = 1'b1, h_wr_n = 1'b1;
    logic [7:0] h_din = '0;
    logic [7:0] h_dout;
    logic       h_dout_en;
    logic       c_op_vld = 1'b0;
    logic [7:0] c_op = '0, c_acc = '0;
    logic       c_obuf_wr = 1'b0, c_ibuf_rd = 1'b0;
    logic [7:0] c_ibuf_q;
    logic       c_f0_wr = 1'b0, c_f0_val = 1'b0;
    logic       c_plat_we = 1'b0;
    logic [1:0] c_plat_d = '0;
    logic [7:0] c_sts;
    logic       pin_obf, pin_ibf_n;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    hsb_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .h_cs_n(h_cs_n), .h_a0(h_a0), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n),
        .h_din(h_din), .h_dout(h_dout), .h_dout_en(h_dout_en),
        .c_op_vld(c_op_vld), .c_op(c_op), .c_acc(c_acc),
        .c_obuf_wr(c_obuf_wr), .c_ibuf_rd(c_ibuf_rd), .c_ibuf_q(c_ibuf_q),
        .c_f0_wr(c_f0_wr), .c_f0_val(c_f0_val),
        .c_plat_we(c_plat_we), .c_plat_d(c_plat_d),
        .c_sts(c_sts), .pin_obf(pin_obf), .pin_ibf_n(pin_ibf_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic a0, input logic [7:0] d, input logic cs_n);
        h_cs_n = cs_n; h_a0 = a0; h_din = d;
        tick(1); h_wr_n = 1'b0;
        tick(6); h_wr_n = 1'b1;
        tick(5); h_cs_n = 1'b1;
        tick(2);
    endtask

    task automatic host_read(input logic a0, input logic cs_n, output logic [7:0] d, output logic en);
        h_cs_n = cs_n; h_a0 = a0;
        tick(1); h_rd_n = 1'b0;
        tick(6); d = h_dout; en = h_dout_en;
        h_rd_n = 1'b1;
        tick(5); h_cs_n = 1'b1;
        tick(2);
    endtask

    task automatic core_op(input logic [7:0] op, input logic [7:0] acc);
        c_op_vld = 1'b1; c_op = op; c_acc = acc;
        tick(1); c_op_vld = 1'b0;
        tick(2);
    endtask

    task automatic core_obuf(input logic [7:0] d);
        c_obuf_wr = 1'b1; c_acc = d;
        tick(1); c_obuf_wr = 1'b0;
        tick(2);
    endtask

    task automatic core_ird();
        c_ibuf_rd = 1'b1;
        tick(1); c_ibuf_rd = 1'b0;
        tick(2);
    endtask

    task automatic core_f0(input logic v);
        c_f0_wr = 1'b1; c_f0_val = v;
        tick(1); c_f0_wr = 1'b0;
        tick(2);
    endtask

    task automatic core_plat(input logic [1:0] v);
        c_plat_we = 1'b1; c_plat_d = v;
        tick(1); c_plat_we = 1'b0;
        tick(2);
    endtask

    task automatic set_ibf(input logic v);
        if (v && !c_sts[1]) host_write(1'b0, 8'h00, 1'b0);
        if (!v && c_sts[1]) core_ird();
    endtask

    task automatic set_obf(input logic v);
        logic [7:0] d;
        logic       e;
        if (v && !c_sts[0]) core_obuf(8'h00);
        if (!v && c_sts[0]) host_read(1'b0, 1'b0, d, e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, old, expv, prev_lo, usr;
        logic       e;
        tick(1);
        do_reset();

        // R1 reset state
        chk(c_sts == 8'h00, "R1 status", c_sts, 8'h00);
        chk(c_ibuf_q == 8'h00, "R1 ibuf", c_ibuf_q, 8'h00);
        chk({pin_ibf_n, pin_obf} == 2'b11, "R1 pins", {pin_ibf_n, pin_obf}, 2'b11);
        chk(h_dout_en == 1'b0, "R1 dout_en", h_dout_en, 1'b0);

        // R2 trailing edge: flags unchanged while the strobe is low
        h_cs_n = 1'b0; h_a0 = 1'b1; h_din = 8'h3C;
        tick(1); h_wr_n = 1'b0;
        tick(8);
        chk(c_sts[1] == 1'b0 && c_sts[3] == 1'b0, "R2 strobe low", c_sts, 8'h00);
        h_wr_n = 1'b1;
        tick(5); h_cs_n = 1'b1; tick(2);
        chk(c_sts[1] == 1'b1 && c_sts[3] == 1'b1 && c_ibuf_q == 8'h3C, "R2 after edge", {c_sts, c_ibuf_q}, {8'h0A, 8'h3C});
        core_ird();

        // R2 R5 sweep all host write data values
        for (int v = 0; v < 256; v++) begin
            host_write(v[0], v[7:0], 1'b0);
            chk(c_sts[1] == 1'b1 && c_sts[3] == v[0] && c_ibuf_q == v[7:0], "R2 write sweep",
                {c_sts[3], c_sts[1], c_ibuf_q}, {v[0], 1'b1, v[7:0]});
            core_ird();
            chk(c_sts[1] == 1'b0, "R5 ibuf read clears", c_sts[1], 1'b0);
        end

        // R3 R5 sweep all outbound values
        for (int v = 0; v < 256; v++) begin
            core_obuf(v[7:0]);
            chk(c_sts[0] == 1'b1, "R5 obuf write sets", c_sts[0], 1'b1);
            host_read(1'b0, 1'b0, d, e);
            chk(d == v[7:0] && e == 1'b1, "R3 data read", {e, d}, {1'b1, v[7:0]});
            chk(c_sts[0] == 1'b0, "R3 obf cleared", c_sts[0], 1'b0);
        end

        // R7 core flag
        core_f0(1'b1);
        chk(c_sts[2] == 1'b1, "R7 f0 set", c_sts[2], 1'b1);
        host_write(1'b1, 8'h11, 1'b0);
        core_obuf(8'h22);
        host_read(1'b0, 1'b0, d, e);
        host_read(1'b1, 1'b0, d, e);
        chk(c_sts[2] == 1'b1, "R7 host leaves f0", c_sts[2], 1'b1);

        // R4 status layout: usr=5 f1=1 f0=1 ibf=1 obf=1
        core_op(8'h90, 8'h5A);
        core_obuf(8'h77);
        expv = {4'h5, 1'b1, 1'b1, 1'b1, 1'b1};
        host_read(1'b1, 1'b0, d, e);
        chk(d == expv, "R4 status read", d, expv);
        chk(c_sts == expv, "R4 no flag change", c_sts, expv);
        core_f0(1'b0);
        chk(c_sts[2] == 1'b0, "R7 f0 clear", c_sts[2], 1'b0);
        set_ibf(1'b0);
        set_obf(1'b0);

        // R6 user nibble sweep
        for (int u = 0; u < 16; u++) begin
            prev_lo = c_sts;
            core_op(8'h90, {u[3:0], ~u[3:0]});
            chk(c_sts[7:4] == u[3:0] && c_sts[3:0] == prev_lo[3:0], "R6 upload",
                c_sts, {u[3:0], prev_lo[3:0]});
        end

        // R6 R9 all other opcodes: no user change, no flag mode
        core_plat(2'b01);
        usr = c_sts;
        for (int op = 0; op < 256; op++) begin
            if (op != 8'h90 && op != 8'hF5) begin
                core_op(op[7:0], 8'hA5 ^ op[7:0]);
                chk(c_sts == usr, "R6 other opcode", c_sts, usr);
                chk({pin_ibf_n, pin_obf} == 2'b01, "R9 stays port mode", {pin_ibf_n, pin_obf}, 2'b01);
            end
        end

        // R9 port mode pins follow latches
        for (int l = 0; l < 4; l++) begin
            core_plat(l[1:0]);
            chk({pin_ibf_n, pin_obf} == l[1:0], "R9 port pins", {pin_ibf_n, pin_obf}, l[1:0]);
        end

        // R12 deselected strobes ignored
        host_write(1'b1, 8'hEE, 1'b0);
        core_ird();
        old = c_ibuf_q;
        host_write(1'b0, 8'h5D, 1'b1);
        chk(c_sts[1] == 1'b0 && c_ibuf_q == old, "R12 write ignored", {c_sts[1], c_ibuf_q}, {1'b0, old});
        core_obuf(8'h66);
        host_read(1'b0, 1'b1, d, e);
        chk(c_sts[0] == 1'b1 && e == 1'b0, "R12 read ignored", {c_sts[0], e}, 2'b10);
        set_obf(1'b0);

        // R8 status lock during host status read
        core_op(8'h90, 8'h00);
        old = c_sts;
        h_cs_n = 1'b0; h_a0 = 1'b1;
        tick(1); h_rd_n = 1'b0;
        tick(6);
        core_op(8'h90, 8'hA0);
        core_obuf(8'h44);
        tick(2);
        chk(h_dout == old, "R8 frozen during read", h_dout, old);
        chk(c_sts[7:4] == 4'hA && c_sts[0] == 1'b1, "R8 live updates", c_sts, {4'hA, old[3:1], 1'b1});
        h_rd_n = 1'b1;
        tick(5); h_cs_n = 1'b1; tick(2);
        expv = {4'hA, old[3:1], 1'b1};
        host_read(1'b1, 1'b0, d, e);
        chk(d == expv, "R8 applied after read", d, expv);
        set_obf(1'b0);

        // R9 enter flag mode
        core_op(8'hF5, 8'h00);

        // R10 exhaustive latch x ibf x obf
        for (int l = 0; l < 4; l++) begin
            for (int i = 0; i < 2; i++) begin
                for (int o = 0; o < 2; o++) begin
                    set_ibf(i[0]);
                    set_obf(o[0]);
                    core_plat(l[1:0]);
                    tick(2);
                    chk(pin_obf == (l[0] & o[0]) && pin_ibf_n == (l[1] & ~i[0]), "R10 flag pins",
                        {pin_ibf_n, pin_obf}, {l[1] & ~i[0], l[0] & o[0]});
                end
            end
        end

        // R9 flag mode sticky across opcodes
        set_ibf(1'b0);
        set_obf(1'b0);
        core_plat(2'b01);
        core_op(8'h90, 8'h00);
        core_op(8'h00, 8'h00);
        core_op(8'hF5, 8'h00);
        chk(pin_obf == 1'b0, "R9 flag mode kept", pin_obf, 1'b0);

        // R11 host write end collides with core inbound read
        set_ibf(1'b0);
        h_cs_n = 1'b0; h_a0 = 1'b0; h_din = 8'h9B;
        tick(1); h_wr_n = 1'b0;
        tick(6); h_wr_n = 1'b1;
        tick(2); c_ibuf_rd = 1'b1;
        tick(1); c_ibuf_rd = 1'b0;
        tick(3); h_cs_n = 1'b1; tick(2);
        chk(c_sts[1] == 1'b1 && c_ibuf_q == 8'h9B, "R11 write wins", {c_sts[1], c_ibuf_q}, {1'b1, 8'h9B});
        core_ird();

        // R11 host data read end collides with core outbound write
        core_obuf(8'h12);
        h_cs_n = 1'b0; h_a0 = 1'b0;
        tick(1); h_rd_n = 1'b0;
        tick(6); h_rd_n = 1'b1;
        tick(2); c_obuf_wr = 1'b1; c_acc = 8'hC7;
        tick(1); c_obuf_wr = 1'b0;
        tick(3); h_cs_n = 1'b1; tick(2);
        chk(c_sts[0] == 1'b1, "R11 obuf write wins", c_sts[0], 1'b1);
        host_read(1'b0, 1'b0, d, e);
        chk(d == 8'hC7, "R11 new byte kept", d, 8'hC7);

        // R9 reset leaves flag mode
        do_reset();
        chk({pin_ibf_n, pin_obf} == 2'b11 && c_sts == 8'h00, "R9 reset to port mode",
            {c_sts, pin_ibf_n, pin_obf}, {8'h00, 2'b11});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule